// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt request lines and presents one active-low interrupt line to a processor. Each source has its own mode word, which holds a 3-bit priority and a trigger type (level low, level high, falling edge or rising edge), and its own 32-bit vector word. Software enables and disables sources, and clears or forces their latched edges, through command words. In each of these words only the bits written as one have an effect.

When the processor takes the interrupt, it reads the vector word. The block returns the vector of the best enabled pending source and records that source as current by pushing its level onto an internal nesting stack that is 8 entries deep. After that, only a source with a strictly higher priority can raise the interrupt line again. Each service routine ends with a write to the end-of-interrupt word, which pops one level. If no source qualifies, the read returns a programmable spurious vector. A debug word selects a protect mode, in which reads have no side effects, and a general mask that holds the interrupt line inactive.

Top module: `pic_top`

## Requirements
- R1: After reset the interrupt line is high (inactive), the mask (0x110), status (0x108) and core status (0x114) words read 0, and a vector read (0x100) returns the spurious value, which resets to 0.
- R2: A mode word at byte address n*4 holds the priority in bits [2:0] (7 highest) and the trigger in bits [6:5]: 00 level low, 01 falling edge, 10 level high, 11 rising edge. Other bits read 0. A level source shows in the pending word (0x10C) whenever its input is at the active level.
- R3: An edge source latches pending on the selected edge and ignores the opposite edge. The latch stays set after the input returns and is cleared by its acknowledge or by a one in the clear word (0x128). A one in the set word (0x12C) sets the latch of an edge source and has no effect on a level source.
- R4: A one in the enable word (0x120) sets the bit in the mask word (0x110) and a one in the disable word (0x124) clears it. Zero bits leave the mask unchanged.
- R5: The interrupt line goes low on the clock edge after an enabled pending source has a priority above the top stack level, or as soon as one is pending while the stack is empty. When no such source exists it is high.
- R6: Reading 0x100 returns the vector word (0x80+n*4) of the highest-priority qualifying source, with the lowest index winning a tie. The read pushes that source, and the status word then reads its index in bits [4:0].
- R7: When no source qualifies, a vector read returns the spurious word (0x134), pushes nothing and leaves the status word unchanged.
- R8: A source whose priority is equal to or lower than the current level does not assert the interrupt line.
- R9: A write to 0x130 pops one level whatever the data written, so the status word then shows the previous current source (0 when the stack is empty). Eight pops always empty the stack, and a pop on an empty stack has no effect.
- R10: Debug word (0x138) bit 0 selects protect mode: a vector read returns the same value but has no side effect, and a write to 0x100 performs the acknowledge. Bit 1 holds the interrupt line high.
- R11: The core status word reports the interrupt line as active in bit 1. Bit 0, the fast line, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Interrupt request inputs, synchronous to clk |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd is high |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The checker covers the properties that hold on every cycle: the stack never passes its depth, every pop removes exactly one level, an accepted acknowledge leaves the stack non-empty, the general mask keeps the line high, the line falls only when some enabled source was pending, and a vector read with no winner returns the spurious word. Only the scenarios can show the ordering behaviour: which source wins a tie, that equal priorities do not preempt, that a pop exposes the source nested below, that an edge latch survives until it is acknowledged or cleared, and that a vector read in protect mode leaves the state unchanged.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int ID_W     = 5;
    localparam int PRIO_W   = 3;
    localparam int DATA_W   = 32;
    localparam int WORD_W   = 7;

    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'b00,
        TRIG_FALL   = 2'b01,
        TRIG_LVL_HI = 2'b10,
        TRIG_RISE   = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e               trig;
        logic [PRIO_W-1:0]   prio;
    } src_mode_t;

    typedef struct packed {
        logic [PRIO_W-1:0]   prio;
        logic [ID_W-1:0]     id;
    } lvl_t;

    typedef struct packed {
        logic                hit;
        lvl_t                lvl;
    } pick_t;

    // word addresses (byte address >> 2)
    localparam logic [WORD_W-1:0] W_VEC_BASE = 7'h20;
    localparam logic [WORD_W-1:0] W_IVR      = 7'h40;
    localparam logic [WORD_W-1:0] W_ISR      = 7'h42;
    localparam logic [WORD_W-1:0] W_PEND     = 7'h43;
    localparam logic [WORD_W-1:0] W_MASK     = 7'h44;
    localparam logic [WORD_W-1:0] W_CORE     = 7'h45;
    localparam logic [WORD_W-1:0] W_EN       = 7'h48;
    localparam logic [WORD_W-1:0] W_DIS      = 7'h49;
    localparam logic [WORD_W-1:0] W_CLR      = 7'h4A;
    localparam logic [WORD_W-1:0] W_SET      = 7'h4B;
    localparam logic [WORD_W-1:0] W_EOI      = 7'h4C;
    localparam logic [WORD_W-1:0] W_SPU      = 7'h4D;
    localparam logic [WORD_W-1:0] W_DBG      = 7'h4E;

    function automatic src_mode_t unpack_mode(input logic [DATA_W-1:0] w);
        src_mode_t m;
        m.trig = trig_e'(w[6:5]);
        m.prio = w[PRIO_W-1:0];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input src_mode_t m);
        return {25'd0, m.trig, 2'b00, m.prio};
    endfunction

    function automatic logic is_edge_mode(input trig_e t);
        return t[0];
    endfunction

    function automatic logic level_active(input trig_e t, input logic s);
        return (t == TRIG_LVL_HI) ? s : ~s;
    endfunction

endpackage

// File: rtl/pic_source.sv
module pic_source
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      src,
    input  src_mode_t mode,
    input  logic      set_cmd,
    input  logic      clr_cmd,
    input  logic      ack_clr,
    output logic      pending
);

    logic prev_q;
    logic latch_q;
    logic edge_ev;
    logic edge_mode;

    assign edge_mode = is_edge_mode(mode.trig);

    always_comb begin
        case (mode.trig)
            TRIG_RISE: edge_ev = src & ~prev_q;
            TRIG_FALL: edge_ev = ~src & prev_q;
            default:   edge_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= src;
            if (!edge_mode)
                latch_q <= 1'b0;
            else if (edge_ev || set_cmd)
                latch_q <= 1'b1;
            else if (clr_cmd || ack_clr)
                latch_q <= 1'b0;
        end
    end

    assign pending = edge_mode ? latch_q : level_active(mode.trig, src);

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thr_prio,
    input  logic                           thr_valid,
    output pick_t                          pick
);

    logic              found;
    logic [PRIO_W-1:0] best_prio;
    logic [ID_W-1:0]   best_id;

    // strict compare keeps the lowest index on a tie
    always_comb begin
        found     = 1'b0;
        best_prio = '0;
        best_id   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!found || prio[i] > best_prio)) begin
                found     = 1'b1;
                best_prio = prio[i];
                best_id   = ID_W'(i);
            end
        end
    end

    always_comb begin
        pick.hit      = found && (!thr_valid || best_prio > thr_prio);
        pick.lvl.prio = best_prio;
        pick.lvl.id   = best_id;
    end

endmodule

// File: rtl/pic_stack.sv
module pic_stack
    import pic_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  lvl_t             push_lvl,
    input  logic             pop,
    output lvl_t             top,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    lvl_t             mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_m1;
    logic             full;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign cnt_m1 = cnt_q - 1'b1;
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            mem[cnt_q[IDX_W-1:0]] <= push_lvl;
            cnt_q                 <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_m1;
        end
    end

    assign top = empty ? '0 : mem[cnt_m1[IDX_W-1:0]];

endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = 8,
    parameter int ADDR_W      = 9,
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);

    logic [WORD_W-1:0] word;
    logic              unused_addr_bits;

    assign word             = bus_addr[ADDR_W-1:2];
    assign unused_addr_bits = ^bus_addr[1:0];

    src_mode_t         mode_q [NUM_SRC];
    logic [DATA_W-1:0] vec_q  [NUM_SRC];
    logic [NUM_SRC-1:0] en_q;
    logic [DATA_W-1:0] spu_q;
    logic              prot_q;
    logic              gmask_q;

    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             req;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
    logic [NUM_SRC-1:0]             set_vec;
    logic [NUM_SRC-1:0]             clr_vec;
    logic [NUM_SRC-1:0]             ack_onehot;

    pick_t             pick;
    lvl_t              stk_top;
    logic              stk_empty;
    logic [CNT_W-1:0]  stk_count;

    logic              ack_req;
    logic              ack_ok;
    logic              eoi_wr;
    logic [DATA_W-1:0] vec_val;
    logic [DATA_W-1:0] isr_val;

    // ---------------- command decode ----------------
    assign set_vec = (bus_wr && word == W_SET) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_vec = (bus_wr && word == W_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign eoi_wr  = bus_wr && (word == W_EOI);
    assign ack_req = prot_q ? (bus_wr && word == W_IVR) : (bus_rd && word == W_IVR);
    assign ack_ok  = ack_req && pick.hit;

    always_comb begin
        ack_onehot = '0;
        if (ack_ok)
            ack_onehot[pick.lvl.id] = 1'b1;
    end

    // ---------------- per-source trigger logic ----------------
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pic_source u_src (
            .clk     (clk),
            .rst     (rst),
            .src     (src_in[g]),
            .mode    (mode_q[g]),
            .set_cmd (set_vec[g]),
            .clr_cmd (clr_vec[g]),
            .ack_clr (ack_onehot[g]),
            .pending (pend[g])
        );
        assign prio_vec[g] = mode_q[g].prio;
    end

    assign req = pend & en_q;

    // ---------------- selection and nesting ----------------
    pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .req       (req),
        .prio      (prio_vec),
        .thr_prio  (stk_top.prio),
        .thr_valid (!stk_empty),
        .pick      (pick)
    );

    pic_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_ok),
        .push_lvl (pick.lvl),
        .pop      (eoi_wr),
        .top      (stk_top),
        .empty    (stk_empty),
        .count    (stk_count)
    );

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                mode_q[i] <= '0;
                vec_q[i]  <= '0;
            end
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (word == WORD_W'(i))
                    mode_q[i] <= unpack_mode(bus_wdata);
                if (word == W_VEC_BASE + WORD_W'(i))
                    vec_q[i] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            spu_q   <= '0;
            prot_q  <= 1'b0;
            gmask_q <= 1'b0;
        end else if (bus_wr) begin
            case (word)
                W_EN:  en_q <= en_q | bus_wdata[NUM_SRC-1:0];
                W_DIS: en_q <= en_q & ~bus_wdata[NUM_SRC-1:0];
                W_SPU: spu_q <= bus_wdata;
                W_DBG: begin
                    prot_q  <= bus_wdata[0];
                    gmask_q <= bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    // ---------------- interrupt line ----------------
    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else
            irq_n <= ~(pick.hit && !gmask_q);
    end

    // ---------------- read side ----------------
    assign vec_val = pick.hit ? vec_q[pick.lvl.id] : spu_q;
    assign isr_val = stk_empty ? '0 : {{(DATA_W-ID_W){1'b0}}, stk_top.id};

    always_comb begin
        bus_rdata = '0;
        if (word < WORD_W'(NUM_SRC)) begin
            bus_rdata = pack_mode(mode_q[word[ID_W-1:0]]);
        end else if (word >= W_VEC_BASE && word < W_VEC_BASE + WORD_W'(NUM_SRC)) begin
            bus_rdata = vec_q[word[ID_W-1:0]];
        end else begin
            case (word)
                W_IVR:  bus_rdata = vec_val;
                W_ISR:  bus_rdata = isr_val;
                W_PEND: bus_rdata = DATA_W'(pend);
                W_MASK: bus_rdata = DATA_W'(en_q);
                W_CORE: bus_rdata = {{(DATA_W-2){1'b0}}, ~irq_n, 1'b0};
                W_SPU:  bus_rdata = spu_q;
                W_DBG:  bus_rdata = {{(DATA_W-2){1'b0}}, gmask_q, prot_q};
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pic_chk.sv
module pic_chk
    import pic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_n,
    input logic              gmask_q,
    input logic [NSRC-1:0]   req,
    input logic [CNT_W-1:0]  stk_count,
    input logic              stk_empty,
    input logic              eoi_wr,
    input logic              ack_ok,
    input logic              bus_rd,
    input logic [WORD_W-1:0] word,
    input logic              pick_hit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] spu_q
);

    // R9
    stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stk_count <= CNT_W'(DEPTH));

    // R9
    eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !ack_ok && stk_count != '0) |=> (stk_count == $past(stk_count) - 1'b1));

    // R6
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        ack_ok |=> !stk_empty);

    // R10
    gmask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        gmask_q |=> irq_n);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> $past(|req));

    // R7
    spurious_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && word == W_IVR && !pick_hit) |-> (bus_rdata == spu_q));

endmodule

bind pic_top pic_chk #(
    .NSRC  (NUM_SRC),
    .DEPTH (STACK_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_n     (irq_n),
    .gmask_q   (gmask_q),
    .req       (req),
    .stk_count (stk_count),
    .stk_empty (stk_empty),
    .eoi_wr    (eoi_wr),
    .ack_ok    (ack_ok),
    .bus_rd    (bus_rd),
    .word      (word),
    .pick_hit  (pick.hit),
    .bus_rdata (bus_rdata),
    .spu_q     (spu_q)
);

// File: tb/tb_pic_top.sv
module tb_pic_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [8:0] A_IVR  = 9'h100;
    localparam logic [8:0] A_ISR  = 9'h108;
    localparam logic [8:0] A_PEND = 9'h10C;
    localparam logic [8:0] A_MASK = 9'h110;
    localparam logic [8:0] A_CORE = 9'h114;
    localparam logic [8:0] A_EN   = 9'h120;
    localparam logic [8:0] A_DIS  = 9'h124;
    localparam logic [8:0] A_CLR  = 9'h128;
    localparam logic [8:0] A_SET  = 9'h12C;
    localparam logic [8:0] A_EOI  = 9'h130;
    localparam logic [8:0] A_SPU  = 9'h134;
    localparam logic [8:0] A_DBG  = 9'h138;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_top dut (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    function automatic logic [8:0] mode_a(input int n);
        return 9'(n * 4);
    endfunction

    function automatic logic [8:0] vec_a(input int n);
        return 9'(32'h80 + n * 4);
    endfunction

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // scoreboard monitor: compares every read against the queued expectation
    always @(negedge clk) begin
        if (bus_rd && !rst) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: got %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        #1;
        bus_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s: irq_n got %b expected %b", tag, irq_n, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b1, "R1 irq after reset");
        rd(A_MASK, 32'h0, "R1 mask");
        rd(A_ISR,  32'h0, "R1 status");
        rd(A_CORE, 32'h0, "R1 core status");
        rd(A_IVR,  32'h0, "R1 spurious default");
        // R2 reset mode is level low, inputs low -> all pending
        rd(A_PEND, 32'hFFFF_FFFF, "R2 level low pending");

        for (int n = 0; n < 32; n++) begin
            wr(mode_a(n), 32'h40);
            wr(vec_a(n), 32'h1000 + n);
        end
        wr(A_SPU, 32'hDEAD);
        rd(A_SPU, 32'hDEAD, "R7 spurious word");

        // R2 level triggers and mode field layout
        rd(A_PEND, 32'h0, "R2 level high idle");
        src_in[3] = 1'b1;
        wr(mode_a(4), 32'h0);
        idle(1);
        rd(A_PEND, 32'h18, "R2 level high and low");
        wr(mode_a(2), 32'hFFFF_FFFF);
        rd(mode_a(2), 32'h67, "R2 mode field bits");
        wr(mode_a(2), 32'h40);
        wr(mode_a(4), 32'h40);
        src_in[3] = 1'b0;

        // R4 enable / disable
        wr(A_EN, 32'hF0);
        rd(A_MASK, 32'hF0, "R4 enable");
        wr(A_DIS, 32'h30);
        rd(A_MASK, 32'hC0, "R4 disable");
        wr(A_EN, 32'h01);
        rd(A_MASK, 32'hC1, "R4 zero bits kept");
        wr(A_DIS, 32'hFFFF_FFFF);
        rd(A_MASK, 32'h0, "R4 disable all");

        // R5 R6 R8 R9 nesting
        wr(mode_a(3), 32'h42);
        wr(mode_a(5), 32'h45);
        wr(mode_a(6), 32'h43);
        wr(A_EN, 32'h68);
        idle(2);
        chk_irq(1'b1, "R5 nothing pending");
        src_in[3] = 1'b1;
        idle(2);
        chk_irq(1'b0, "R5 irq asserted");
        rd(A_CORE, 32'h2, "R11 core status irq bit");
        rd(A_IVR, 32'h1003, "R6 vector src3");
        rd(A_ISR, 32'h3, "R6 status src3");
        idle(1);
        chk_irq(1'b1, "R8 equal level no preempt");
        src_in[5] = 1'b1;
        idle(2);
        chk_irq(1'b0, "R5 higher preempts");
        rd(A_IVR, 32'h1005, "R6 vector src5");
        rd(A_ISR, 32'h5, "R6 status src5");
        src_in[6] = 1'b1;
        idle(2);
        chk_irq(1'b1, "R8 lower level blocked");
        src_in[5] = 1'b0;
        wr(A_EOI, 32'hFFFF_FFFF);
        rd(A_ISR, 32'h3, "R9 pop exposes src3");
        chk_irq(1'b0, "R5 src6 above src3");
        rd(A_IVR, 32'h1006, "R6 vector src6");
        rd(A_ISR, 32'h6, "R6 status src6");
        wr(A_EOI, 32'h0);
        wr(A_EOI, 32'h0);
        rd(A_ISR, 32'h0, "R9 stack empty");
        chk_irq(1'b0, "R5 empty stack pending");
        repeat (8) wr(A_EOI, 32'h0);
        rd(A_IVR, 32'h1006, "R9 pop on empty no effect");
        rd(A_ISR, 32'h6, "R9 status after empty pops");
        wr(A_EOI, 32'h0);
        rd(A_ISR, 32'h0, "R9 single pop empties");
        src_in = '0;
        wr(A_DIS, 32'hFFFF_FFFF);

        // R9 eight-deep nesting
        for (int k = 0; k < 8; k++) wr(mode_a(16 + k), 32'h40 | k);
        wr(A_EN, 32'h00FF_0000);
        for (int k = 0; k < 8; k++) begin
            src_in[16 + k] = 1'b1;
            idle(2);
            rd(A_IVR, 32'h1010 + k, "R9 nested vector");
        end
        rd(A_ISR, 32'd23, "R9 deepest status");
        chk_irq(1'b1, "R8 top level 7");
        repeat (8) wr(A_EOI, 32'h0);
        rd(A_ISR, 32'h0, "R9 eight pops empty");
        src_in = '0;
        wr(A_DIS, 32'hFFFF_FFFF);

        // R6 tie: lowest index wins
        wr(mode_a(7), 32'h44);
        wr(mode_a(9), 32'h44);
        wr(A_EN, 32'h280);
        src_in[7] = 1'b1;
        src_in[9] = 1'b1;
        idle(2);
        rd(A_IVR, 32'h1007, "R6 tie lowest index");
        rd(A_ISR, 32'h7, "R6 tie status");
        wr(A_EOI, 32'h0);
        src_in = '0;
        wr(A_DIS, 32'hFFFF_FFFF);

        // R7 spurious
        rd(A_IVR, 32'hDEAD, "R7 spurious empty");
        rd(A_ISR, 32'h0, "R7 no push");
        wr(A_EN, 32'h28);
        src_in[5] = 1'b1;
        idle(2);
        rd(A_IVR, 32'h1005, "R7 setup ack");
        src_in[3] = 1'b1;
        idle(2);
        chk_irq(1'b1, "R8 lower blocked");
        rd(A_IVR, 32'hDEAD, "R7 spurious nested");
        rd(A_ISR, 32'h5, "R7 status unchanged");
        wr(A_EOI, 32'h0);
        rd(A_ISR, 32'h0, "R7 spurious not pushed");
        src_in = '0;
        wr(A_DIS, 32'hFFFF_FFFF);

        // R3 edge triggers
        wr(mode_a(10), 32'h61);
        idle(1);
        rd(A_PEND, 32'h0, "R3 no edge yet");
        src_in[10] = 1'b1;
        idle(2);
        src_in[10] = 1'b0;
        idle(2);
        rd(A_PEND, 32'h400, "R3 rising latched");
        wr(A_CLR, 32'h400);
        rd(A_PEND, 32'h0, "R3 clear command");
        wr(A_SET, 32'h400);
        rd(A_PEND, 32'h400, "R3 set command");
        wr(A_SET, 32'h1000);
        rd(A_PEND, 32'h400, "R3 set on level ignored");
        wr(A_EN, 32'h400);
        idle(2);
        chk_irq(1'b0, "R3 edge asserts irq");
        rd(A_IVR, 32'h100A, "R3 edge vector");
        rd(A_PEND, 32'h0, "R3 ack clears latch");
        wr(A_EOI, 32'h0);
        idle(2);
        chk_irq(1'b1, "R3 no repeat after ack");
        wr(mode_a(11), 32'h21);
        src_in[11] = 1'b1;
        idle(2);
        rd(A_PEND, 32'h0, "R3 falling ignores rise");
        src_in[11] = 1'b0;
        idle(2);
        rd(A_PEND, 32'h800, "R3 falling latched");
        wr(A_CLR, 32'h800);
        rd(A_PEND, 32'h0, "R3 falling cleared");
        wr(A_DIS, 32'hFFFF_FFFF);

        // R10 protect mode and general mask
        wr(A_DBG, 32'h1);
        rd(A_DBG, 32'h1, "R10 debug word");
        src_in[5] = 1'b1;
        wr(A_EN, 32'h20);
        idle(2);
        chk_irq(1'b0, "R10 irq before read");
        rd(A_IVR, 32'h1005, "R10 protect read value");
        rd(A_ISR, 32'h0, "R10 protect read no push");
        chk_irq(1'b0, "R10 irq kept");
        wr(A_IVR, 32'h0);
        rd(A_ISR, 32'h5, "R10 write acknowledges");
        chk_irq(1'b1, "R10 irq after write ack");
        wr(A_EOI, 32'h0);
        idle(2);
        chk_irq(1'b0, "R10 irq after pop");
        wr(A_DBG, 32'h2);
        idle(2);
        chk_irq(1'b1, "R10 general mask");
        rd(A_CORE, 32'h0, "R11 core status masked");
        wr(A_DBG, 32'h0);
        idle(2);
        chk_irq(1'b0, "R10 mask released");
        rd(A_IVR, 32'h1005, "R10 normal read acks");
        rd(A_ISR, 32'h5, "R10 normal push");
        wr(A_EOI, 32'h0);
        idle(2);

        report();
        $finish;
    end

endmodule